// File: doc/BRIEF.md
# Flash Converter Digital Back End

This block is the clocked digital half of a 7-bit flash analog-to-digital converter. A bank of 128 comparators, each tied to one tap of a reference ladder, presents a thermometer vector: comparator `i` reads 1 when the analog input is at or above its threshold. One clock sets the phases. While the clock is low (sample phase) the block holds the comparator states in an internal stage. When the clock goes high again (auto-zero phase) the encoded result moves into the output register.

The output is a 7-bit straight-binary code plus an overflow flag. In continuous operation a new result comes out on every clock cycle, one sample behind the input. Two chip-select inputs produce separate output-enable signals for the data bits and for the overflow flag. These enables take the place of three-state pins, so a pad ring or a second converter that shares the bus can use them. When two converters are cascaded, the overflow flag of the lower one serves as the eighth bit.

Top module: `flash_backend`

## Requirements
- R1: A comparator vector held steady over a falling clock edge shows at `codeOut`/`ovfOut` just after the next rising edge, and not before it. A new vector may be applied every cycle, and each one appears exactly one cycle after it is applied.
- R2: For a clean thermometer vector with the lowest k comparators tripped, 0 <= k <= 127, `codeOut` equals k in straight binary and `ovfOut` is 0.
- R3: The code comes from the highest tripped comparator. A zero hole below that comparator does not change the code: level 20 with comparator 5 cleared still gives 20.
- R4: When comparator 127 (the top one) is tripped, `ovfOut` is 1 and `codeOut` is 7'h7F. Read as {ovfOut, codeOut}, the combined byte is 8'hFF. Overflow never clears the data bits.
- R5: `ovfOut` is 0 whenever comparator 127 was not tripped in the sample.
- R6: With `csB` = 0, both `codeOe` and `ovfOe` are 0, whatever the value of `csA`.
- R7: With `csA` = 0 and `csB` = 1, both `codeOe` and `ovfOe` are 1.
- R8: With `csA` = 1 and `csB` = 1, `codeOe` is 0 and `ovfOe` is 1.
- R9: While `rstN` is low, `codeOut` is 0 and `ovfOut` is 0, even if the comparators are tripped. Asserting `rstN` clears the outputs at once, without waiting for a clock edge. The enables depend only on the chip selects.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Phase clock: high is auto-zero, low is sample |
| rstN | input | 1 | Asynchronous active-low reset |
| compIn | input | 128 | Comparator states, bit i is threshold i |
| csA | input | 1 | Chip select that masks the data bits when high |
| csB | input | 1 | Master chip select, active high |
| codeOut | output | 7 | Straight-binary conversion result |
| ovfOut | output | 1 | Overflow flag, set when the top comparator trips |
| codeOe | output | 1 | Drive enable for `codeOut` |
| ovfOe | output | 1 | Drive enable for `ovfOut` |

## Verification
The pipeline properties assume that `compIn` does not change between a falling edge and the following rising edge. Under that assumption, the value sampled at a rising edge is the value the internal stage captured half a cycle earlier. The stimulus keeps to this rule: it changes `compIn` only just after a rising edge, while the clock is high. Reset is released during the high phase, so no capture is cut short. The chip selects are free inputs, and the enable properties hold for any value of them.

// File: rtl/flash_pkg.sv
`timescale 1ns/1ps
package flash_pkg;
  // Output-enable strobes from control to datapath
  typedef struct packed {
    logic codeEn;
    logic ovfEn;
  } oeStrobe_t;
endpackage

// File: rtl/flash_encoder.sv
`timescale 1ns/1ps
module flash_encoder #(
  parameter int CODE_W = 7
) (
  input  logic [(1<<CODE_W)-1:0] therm,
  output logic [CODE_W-1:0]      code,
  output logic                   ovf
);
  localparam int LEVELS = 1 << CODE_W;

  // Highest tripped position wins; holes below it are ignored
  always_comb begin
    code = '0;
    ovf  = 1'b0;
    for (int i = 0; i < LEVELS - 1; i++) begin
      if (therm[i]) code = CODE_W'(i + 1);
    end
    if (therm[LEVELS-1]) begin
      ovf  = 1'b1;
      code = '1;
    end
  end
endmodule

// File: rtl/flash_ctrl.sv
`timescale 1ns/1ps
module flash_ctrl
  import flash_pkg::*;
(
  input  logic       csA,
  input  logic       csB,
  output oeStrobe_t  strobe
);
  always_comb begin
    strobe.ovfEn  = csB;
    strobe.codeEn = csB & ~csA;
  end
endmodule

// File: rtl/flash_datapath.sv
`timescale 1ns/1ps
module flash_datapath
  import flash_pkg::*;
#(
  parameter int CODE_W = 7
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [(1<<CODE_W)-1:0] compIn,
  input  oeStrobe_t              strobe,
  output logic [CODE_W-1:0]      codeOut,
  output logic                   ovfOut,
  output logic                   codeOe,
  output logic                   ovfOe
);
  localparam int LEVELS = 1 << CODE_W;

  logic [LEVELS-1:0] sampleQ;
  logic [CODE_W-1:0] encCode;
  logic              encOvf;

  // Sample phase: hold comparator states while the clock is low
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) sampleQ <= '0;
    else       sampleQ <= compIn;
  end

  flash_encoder #(.CODE_W(CODE_W)) u_enc (
    .therm (sampleQ),
    .code  (encCode),
    .ovf   (encOvf)
  );

  // Return to auto-zero: load the output register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeOut <= '0;
      ovfOut  <= 1'b0;
    end else begin
      codeOut <= encCode;
      ovfOut  <= encOvf;
    end
  end

  assign codeOe = strobe.codeEn;
  assign ovfOe  = strobe.ovfEn;
endmodule

// File: rtl/flash_backend.sv
`timescale 1ns/1ps
module flash_backend
  import flash_pkg::*;
#(
  parameter  int CODE_W = 7,
  localparam int LEVELS = 1 << CODE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LEVELS-1:0] compIn,
  input  logic              csA,
  input  logic              csB,
  output logic [CODE_W-1:0] codeOut,
  output logic              ovfOut,
  output logic              codeOe,
  output logic              ovfOe
);
  oeStrobe_t strobe;

  flash_ctrl u_ctrl (
    .csA    (csA),
    .csB    (csB),
    .strobe (strobe)
  );

  flash_datapath #(.CODE_W(CODE_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .compIn  (compIn),
    .strobe  (strobe),
    .codeOut (codeOut),
    .ovfOut  (ovfOut),
    .codeOe  (codeOe),
    .ovfOe   (ovfOe)
  );
endmodule

// File: rtl/flash_backend_chk.sv
`timescale 1ns/1ps
module flash_backend_chk #(
  parameter int CODE_W = 7
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [(1<<CODE_W)-1:0] compIn,
  input logic                   csA,
  input logic                   csB,
  input logic [CODE_W-1:0]      codeOut,
  input logic                   ovfOut,
  input logic                   codeOe,
  input logic                   ovfOe
);
  localparam int LEVELS = 1 << CODE_W;

  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (compIn == '0) |=> (codeOut == '0 && !ovfOut)); // R2
  AST_TOP_FULL: assert property (@(posedge clk) disable iff (!rstN)
    compIn[LEVELS-1] |=> (ovfOut && codeOut == '1)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    !compIn[LEVELS-1] |=> !ovfOut); // R5
  AST_CSB_OFF: assert property (@(posedge clk)
    !csB |-> (!codeOe && !ovfOe)); // R6
  AST_CS_DRIVE: assert property (@(posedge clk)
    (!csA && csB) |-> (codeOe && ovfOe)); // R7
  AST_CS_SPLIT: assert property (@(posedge clk)
    (csA && csB) |-> (!codeOe && ovfOe)); // R8

  always @(negedge clk) begin
    if (!rstN) AST_RESET_CLEAR: assert (codeOut == '0 && !ovfOut); // R9
  end
endmodule

bind flash_backend flash_backend_chk #(.CODE_W(CODE_W)) u_chk (.*);

// File: tb/tb_flash_backend.sv
`timescale 1ns/1ps
module tb_flash_backend;
  localparam int CODE_W = 7;
  localparam int LEVELS = 1 << CODE_W;

  typedef struct packed { logic [7:0] lvl; logic [7:0] exp; } vec_t;
  localparam vec_t VECS [9] = '{
    '{8'd0,   8'h00}, '{8'd1,   8'h01}, '{8'd32,  8'h20},
    '{8'd63,  8'h3F}, '{8'd64,  8'h40}, '{8'd65,  8'h41},
    '{8'd96,  8'h60}, '{8'd127, 8'h7F}, '{8'd128, 8'hFF}
  };

  logic              clk = 1'b0;
  logic              rstN;
  logic [LEVELS-1:0] compIn;
  logic              csA, csB;
  logic [CODE_W-1:0] codeOut;
  logic              ovfOut, codeOe, ovfOe;
  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  flash_backend dut (.*);

  function automatic logic [LEVELS-1:0] thermOf(int k);
    thermOf = '0;
    for (int i = 0; i < LEVELS; i++) if (i < k) thermOf[i] = 1'b1;
  endfunction

  function automatic logic [7:0] expOf(int k);
    return (k >= LEVELS) ? 8'hFF : 8'(k);
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] prev;
    rstN = 1'b0; csA = 1'b0; csB = 1'b1;
    compIn = thermOf(LEVELS);
    step(); step();
    check("R9 reset output", {ovfOut, codeOut}, 8'h00);
    rstN = 1'b1;

    // R2/R4 table walk, with R1 latency check at mid-cycle
    prev = 8'h00;
    step();
    prev = 8'hFF;
    for (int v = 0; v < 9; v++) begin
      compIn = thermOf(int'(VECS[v].lvl));
      #2;
      check("R1 no early change", {ovfOut, codeOut}, prev);
      step();
      check(VECS[v].lvl == 8'd128 ? "R4 table" : "R2 table", {ovfOut, codeOut}, VECS[v].exp);
      prev = VECS[v].exp;
    end

    // R2 full sweep, one new level per cycle
    for (int k = 0; k <= LEVELS; k++) begin
      compIn = thermOf(k);
      step();
      check(k == LEVELS ? "R4 sweep" : "R2 sweep", {ovfOut, codeOut}, expOf(k));
    end

    // R1 back-to-back alternation
    compIn = thermOf(0);    step(); check("R1 b2b 0",   {ovfOut, codeOut}, 8'h00);
    compIn = thermOf(128);  step(); check("R1 b2b 128", {ovfOut, codeOut}, 8'hFF);
    compIn = thermOf(0);    step(); check("R1 b2b 0",   {ovfOut, codeOut}, 8'h00);
    compIn = thermOf(64);   step(); check("R1 b2b 64",  {ovfOut, codeOut}, 8'h40);

    // R3 bubbles below the top
    compIn = thermOf(20); compIn[5] = 1'b0;
    step(); check("R3 hole in 20", {ovfOut, codeOut}, 8'h14);
    compIn = thermOf(128); compIn[60] = 1'b0;
    step(); check("R3 hole in full", {ovfOut, codeOut}, 8'hFF);

    // R5 top untripped with everything else set
    compIn = thermOf(127);
    step(); check("R5 ovf clear", {7'd0, ovfOut}, 8'h00);

    // R6..R8 chip selects
    csA = 1'b0; csB = 1'b0; #1 check("R6 cs 00", {6'd0, codeOe, ovfOe}, 8'h00);
    csA = 1'b1; csB = 1'b0; #1 check("R6 cs 10", {6'd0, codeOe, ovfOe}, 8'h00);
    csA = 1'b0; csB = 1'b1; #1 check("R7 cs 01", {6'd0, codeOe, ovfOe}, 8'h03);
    csA = 1'b1; csB = 1'b1; #1 check("R8 cs 11", {6'd0, codeOe, ovfOe}, 8'h01);
    csA = 1'b0;

    // R9 asynchronous reset mid-run
    compIn = thermOf(128);
    step(); check("R9 pre-reset", {ovfOut, codeOut}, 8'hFF);
    rstN = 1'b0; #0.5;
    check("R9 async clear", {ovfOut, codeOut}, 8'h00);
    check("R9 enables in reset", {6'd0, codeOe, ovfOe}, 8'h03);
    step();
    rstN = 1'b1;
    step(); check("R9 recover", {ovfOut, codeOut}, 8'hFF);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule